// File: doc/BRIEF.md
# Triggered PWM Output Conditioning Stage

This block sits between the raw waveform of a compare/PWM engine and a small group of output pins. It gives each pin a level and an output enable, so the pin can be tri-stated. It does three things to the raw waveform:

- It stretches a one-shot event by a programmable number of time-base periods.
- It can keep the pins undriven until a trigger pulse arrives.
- It applies a common polarity and a programmable shutdown state.

Shutdown has the highest priority. While the shutdown input is high, the shutdown state overrides both the trigger gating and the stretched waveform. The outputs are combinational from the inputs and a small amount of state. The state is the previous raw level, the extension counter and the trigger-release flag.

Top module: `pwm_out_cond`

## Requirements
- R1: With extension count N (0 to 7), a raw pulse lasting one time-base period, aligned tick to tick, makes the logical output active for exactly N+1 periods. N=0 adds no extension.
- R2: The extension counter loads N on a rising edge of the raw input. It decrements only on a time-base tick while the raw input is low, and the stretched output stays active while the raw input is high or the counter is nonzero.
- R3: With trigger mode on (`trig_en`=1) and `cfg_hold`=1, all `pin_oe` bits are 0 until a `trig_pulse` is seen. They become 1 from the cycle after that pulse.
- R4: Once released, the pins stay driven while `trig_en` stays 1. Any cycle with `trig_en`=0 drives the pins and re-arms the hold. With `cfg_hold`=0 or `trig_en`=0, the pins are always driven.
- R5: A `trig_pulse` with `trig_en`=1, arriving while the extension counter is nonzero, reloads the counter to N and so restarts the extension.
- R6: `cfg_pol_low`=0 makes the active level 1 on every pin. `cfg_pol_low`=1 makes it 0. All pins always carry the same level.
- R7: While `shutdown`=1 and `cfg_sd_mode` is 2'b00 or 2'b01, every `pin_oe` is 0 in that same cycle.
- R8: While `shutdown`=1, `cfg_sd_mode`=2'b11 drives the active level and 2'b10 drives the inactive level, both through the polarity. `pin_oe` is 1 even if the trigger hold would otherwise keep the pins undriven.
- R9: Whenever a pin is undriven, its `pin_out` carries the inactive level (equal to `cfg_pol_low`).
- R10: After reset, with all configuration inputs at zero and raw low, every pin is driven (`pin_oe`=1) at level 0, and no extension is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | 1 | Raw compare output (logical, active high) |
| trig_en | input | 1 | Trigger mode enable |
| trig_pulse | input | 1 | Trigger event, one cycle |
| tb_tick | input | 1 | One-cycle pulse at the end of each time-base period |
| shutdown | input | 1 | Shutdown event, level sensitive |
| cfg_hold | input | 1 | Keep pins undriven until triggered (only with trig_en) |
| cfg_os_count | input | 3 | One-shot extension in time-base periods |
| cfg_pol_low | input | 1 | 1 = active-low pins, 0 = active-high |
| cfg_sd_mode | input | 2 | Shutdown state: 11 active, 10 inactive, 0x high-impedance |
| pin_out | output | 3 | Pin levels |
| pin_oe | output | 3 | Pin output enables, 1 = driven |

## Verification
Some properties hold on every cycle:
- the output enables during each class of shutdown
- the uniform level across pins
- the holding of the pins right after trigger mode is entered
- the counter staying frozen between ticks
- the persistence of a trigger release

Other behaviour can only be shown by the bench's timed scenarios:
- the exact stretched duration for each of the eight counts
- the restart of an extension by a late trigger
- the exact shutdown levels under both polarities

The bench also covers the re-arming of the hold when trigger mode drops for one cycle.

// File: rtl/pwm_out_cond_pkg.sv
package pwm_out_cond_pkg;

   // Shutdown state encoding; bit 1 = pins stay driven during shutdown
   typedef enum logic [1:0] {
      SD_FLOAT_A = 2'b00,
      SD_FLOAT_B = 2'b01,
      SD_IDLE    = 2'b10,
      SD_ASSERT  = 2'b11
   } sd_mode_e;

endpackage

// File: rtl/oc_oneshot.sv
module oc_oneshot #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_in,
   input  logic             tb_tick,
   input  logic             restart_req,
   input  logic [CNT_W-1:0] ext_len,
   output logic             stretched
);

   logic             raw_q;
   logic [CNT_W-1:0] cnt;
   logic             busy;
   logic             rise;
   logic             load;

   assign busy = (cnt != '0);
   assign rise = raw_in & ~raw_q;
   assign load = rise | (restart_req & busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
      end else begin
         raw_q <= raw_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= ext_len;
      end else if (tb_tick && !raw_in && busy) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign stretched = raw_in | busy;

   // R2: the counter only moves on a tick or a load
   a_r2_frozen_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!tb_tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/oc_trig_gate.sv
module oc_trig_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_en,
   input  logic trig_pulse,
   input  logic hold_cfg,
   output logic gate_off
);

   logic released;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         released <= 1'b0;
      end else if (!trig_en) begin
         released <= 1'b0;
      end else if (trig_pulse) begin
         released <= 1'b1;
      end
   end

   assign gate_off = trig_en & hold_cfg & ~released;

   // R4: a release persists while trigger mode stays on
   a_r4_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (released && trig_en) |=> released);

   // R4: leaving trigger mode re-arms the hold
   a_r4_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_en |=> !released);

endmodule

// File: rtl/oc_pin_drive.sv
module oc_pin_drive
   import pwm_out_cond_pkg::*;
(
   input  logic     logic_act,
   input  logic     pol_low,
   input  logic     shutdown,
   input  sd_mode_e sd_mode,
   input  logic     gate_off,
   output logic     pin_out,
   output logic     pin_oe
);

   logic lvl;

   always_comb begin
      pin_oe = 1'b1;
      lvl    = 1'b0;
      if (shutdown) begin
         unique case (sd_mode)
            SD_ASSERT:  lvl = 1'b1;
            SD_IDLE:    lvl = 1'b0;
            default:    pin_oe = 1'b0;
         endcase
      end else if (gate_off) begin
         pin_oe = 1'b0;
      end else begin
         lvl = logic_act;
      end
      pin_out = lvl ^ pol_low;
   end

endmodule

// File: rtl/pwm_out_cond.sv
module pwm_out_cond
   import pwm_out_cond_pkg::*;
#(
   parameter int NUM_PINS   = 3,
   parameter int CNT_W      = 3,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                raw_in,
   input  logic                trig_en,
   input  logic                trig_pulse,
   input  logic                tb_tick,
   input  logic                shutdown,
   input  logic                cfg_hold,
   input  logic [CNT_W-1:0]    cfg_os_count,
   input  logic                cfg_pol_low,
   input  logic [1:0]          cfg_sd_mode,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);

   localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   if (NUM_PINS < 1 || NUM_PINS > 16) begin : g_bad_pins
      $error("pwm_out_cond: NUM_PINS must be 1..16");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("pwm_out_cond: CNT_W must be 1..8");
   end
   if (PIN_IDX_W < 1) begin : g_bad_idx
      $error("pwm_out_cond: pin index width underflow");
   end

   logic     logic_act;
   logic     gate_off;
   sd_mode_e sd_mode;

   assign sd_mode = sd_mode_e'(cfg_sd_mode);

   if (STRETCH_EN) begin : g_stretch
      oc_oneshot #(.CNT_W(CNT_W)) u_oneshot (
         .clk         (clk),
         .rst_n       (rst_n),
         .raw_in      (raw_in),
         .tb_tick     (tb_tick),
         .restart_req (trig_en & trig_pulse),
         .ext_len     (cfg_os_count),
         .stretched   (logic_act)
      );
   end else begin : g_passthru
      assign logic_act = raw_in;
   end

   oc_trig_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_en    (trig_en),
      .trig_pulse (trig_pulse),
      .hold_cfg   (cfg_hold),
      .gate_off   (gate_off)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      oc_pin_drive u_drv (
         .logic_act (logic_act),
         .pol_low   (cfg_pol_low),
         .shutdown  (shutdown),
         .sd_mode   (sd_mode),
         .gate_off  (gate_off),
         .pin_out   (pin_out[p]),
         .pin_oe    (pin_oe[p])
      );
   end

   // R7: floating shutdown modes release every pin at once
   a_r7_sd_float: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown && !cfg_sd_mode[1]) |-> (pin_oe == '0));

   // R8: driven shutdown modes override the trigger hold
   a_r8_sd_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown && cfg_sd_mode[1]) |-> (pin_oe == '1));

   // R6: all pins share one level
   a_r6_uniform_level: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(pin_out) == 0) || ($countones(pin_out) == NUM_PINS));

   // R3: entering trigger mode with the hold set leaves the pins undriven
   a_r3_hold_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!shutdown && trig_en && cfg_hold && !$past(trig_en)) |-> (pin_oe == '0));

endmodule

// File: tb/pwm_out_cond_bench.sv
`timescale 1ns/100ps
module pwm_out_cond_bench;

   localparam int NP = 3;

   typedef struct {
      logic [NP-1:0] oe;
      logic [NP-1:0] out;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          raw_in = 1'b0;
   logic          trig_en = 1'b0;
   logic          trig_pulse = 1'b0;
   logic          tb_tick = 1'b0;
   logic          shutdown = 1'b0;
   logic          cfg_hold = 1'b0;
   logic [2:0]    cfg_os_count = 3'd0;
   logic          cfg_pol_low = 1'b0;
   logic [1:0]    cfg_sd_mode = 2'b00;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;

   pwm_out_cond u_pwm_out_cond (
      .clk          (clk),
      .rst_n        (rst_n),
      .raw_in       (raw_in),
      .trig_en      (trig_en),
      .trig_pulse   (trig_pulse),
      .tb_tick      (tb_tick),
      .shutdown     (shutdown),
      .cfg_hold     (cfg_hold),
      .cfg_os_count (cfg_os_count),
      .cfg_pol_low  (cfg_pol_low),
      .cfg_sd_mode  (cfg_sd_mode),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe)
   );

   // Driver: record the expected result for the inputs just applied, then advance
   task automatic step(input logic eoe, input logic eout, input string tag);
      exp_t e;
      e.oe  = {NP{eoe}};
      e.out = {NP{eout}};
      e.tag = tag;
      sb.push_back(e);
      @(posedge clk);
      #1;
   endtask

   // Monitor: compare at the falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (pin_oe !== e.oe || pin_out !== e.out) begin
            errors++;
            $display("FAIL %s: oe=%b out=%b expected oe=%b out=%b at %0t",
                     e.tag, pin_oe, pin_out, e.oe, e.out, $time);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R10: reset state with zero configuration
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R10");

      // R1 R2: duration for every count, period of 4 cycles, tick on last cycle
      for (int n = 0; n < 8; n++) begin
         cfg_os_count = 3'(n);
         for (int i = 0; i < 40; i++) begin
            raw_in  = (i < 4);
            tb_tick = ((i % 4) == 3);
            step(1'b1, (i < 4 * (n + 1)), "R1 R2");
         end
      end

      // R5: trigger in the middle of the extension restarts it
      cfg_os_count = 3'd3;
      trig_en      = 1'b1;
      for (int i = 0; i < 32; i++) begin
         raw_in     = (i < 4);
         tb_tick    = ((i % 4) == 3);
         trig_pulse = (i == 9);
         step(1'b1, (i < 20), "R5");
      end
      trig_en    = 1'b0;
      trig_pulse = 1'b0;
      tb_tick    = 1'b0;

      // R6: active-low polarity, no extension
      cfg_os_count = 3'd0;
      cfg_pol_low  = 1'b1;
      for (int i = 0; i < 6; i++) begin
         raw_in = ((i % 3) != 0);
         step(1'b1, ~raw_in, "R6");
      end
      cfg_pol_low = 1'b0;
      for (int i = 0; i < 4; i++) begin
         raw_in = i[0];
         step(1'b1, raw_in, "R6");
      end

      // R3 R9: pins held undriven at inactive level until triggered
      cfg_pol_low = 1'b1;
      trig_en     = 1'b1;
      cfg_hold    = 1'b1;
      for (int i = 0; i < 5; i++) begin
         raw_in = i[0];
         step(1'b0, 1'b1, "R3 R9");
      end
      trig_pulse = 1'b1;
      raw_in     = 1'b1;
      step(1'b0, 1'b1, "R3");
      trig_pulse = 1'b0;
      for (int i = 0; i < 4; i++) begin
         raw_in = i[0];
         step(1'b1, ~raw_in, "R3");
      end

      // R4: one cycle out of trigger mode re-arms the hold
      raw_in  = 1'b1;
      trig_en = 1'b0;
      step(1'b1, 1'b0, "R4");
      trig_en = 1'b1;
      step(1'b0, 1'b1, "R4");
      step(1'b0, 1'b1, "R4");
      cfg_hold = 1'b0;
      step(1'b1, 1'b0, "R4");
      cfg_hold = 1'b1;
      trig_en  = 1'b0;
      step(1'b1, 1'b0, "R4");

      // R7 R8: each shutdown mode under both polarities, with the hold active
      trig_en = 1'b1;
      raw_in  = 1'b1;
      for (int pol = 0; pol < 2; pol++) begin
         cfg_pol_low = pol[0];
         for (int m = 0; m < 4; m++) begin
            cfg_sd_mode = 2'(m);
            shutdown    = 1'b1;
            for (int k = 0; k < 2; k++) begin
               if (m < 2)       step(1'b0, pol[0], "R7");
               else if (m == 2) step(1'b1, pol[0], "R8");
               else             step(1'b1, ~pol[0], "R8");
            end
            shutdown = 1'b0;
            step(1'b0, pol[0], "R9");
         end
      end

      shutdown = 1'b0;
      trig_en  = 1'b0;
      raw_in   = 1'b0;
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule